// File: doc/BRIEF.md
# Two-Player Dice Duel

This block runs a dice game for two players from one system clock. Each player owns a die counter that steps through the faces 1, 2, 3, 4, 5, 6 and back to 1 while that player's active-low roll input is held low; letting go of the input freezes the face. The two dice step on single-cycle clock enables from two free-running dividers with different periods. Because the rates differ, the faces at release look unrelated to each other.

A registered comparator drives three result flags: player A ahead, player B ahead, or a tie. Exactly one flag is high on every cycle. Two seven-segment outputs show each player's current face with active-high segments. The decimal point is always dark.

Top module: `dice_duel`

## Requirements
- R1: While `rst` is high at a clock edge, both dice load face 1, both tick dividers restart, and the flags become `tie`=1, `a_high`=0, `b_high`=0. Both segment outputs then read 0x06.
- R2: One clock after die A's face is greater than die B's, `a_high`=1 and `b_high`=`tie`=0.
- R3: One clock after die A's face is less than die B's, `b_high`=1 and `a_high`=`tie`=0.
- R4: One clock after the two faces are equal, `tie`=1 and `a_high`=`b_high`=0.
- R5: On every cycle after reset, exactly one of `a_high`, `b_high` and `tie` is high.
- R6: A die advances by one face on each of its ticks while its roll input is low. From face 6 it advances to face 1, so face 0 and faces 7 never appear.
- R7: While a die's roll input is high at its tick, that die keeps its face.
- R8: Die A's tick occurs every `PERIOD_A` clocks and die B's every `PERIOD_B` clocks. The first tick falls on the `PERIOD`-th clock edge after reset is released. The dividers run whether or not the roll inputs are low.
- R9: Each segment output follows its die's face in the same cycle. Bit 0 is segment a and bit 6 is segment g, with face 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D and 6=0x7D. Bit 7, the decimal point, is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| roll_a_n | input | 1 | Player A roll, active low |
| roll_b_n | input | 1 | Player B roll, active low |
| a_high | output | 1 | Player A's face is higher |
| b_high | output | 1 | Player B's face is higher |
| tie | output | 1 | The faces are equal |
| seg_a | output | 8 | Segment pattern for player A's digit, decimal point at bit 7 |
| seg_b | output | 8 | Segment pattern for player B's digit, decimal point at bit 7 |

## Verification
The bench builds the block with `PERIOD_A`=3 and `PERIOD_B`=5. With these values a die completes a full wrap from 6 to 1 within a few dozen cycles. Because the two periods are coprime, all 36 face pairs come up during a run of a few thousand cycles, so every ordering of the two faces is compared many times. The roll inputs follow held, released and interleaved patterns. A reset in mid-game shows that the dividers restart together with the dice.

// File: rtl/dice_pkg.sv
package dice_pkg;

    localparam int FACE_W   = 3;
    localparam int SEG_W    = 8;
    localparam int FACE_MIN = 1;
    localparam int FACE_MAX = 6;

    typedef logic [FACE_W-1:0] face_t;
    typedef logic [SEG_W-1:0]  seg_t;

    typedef struct packed {
        logic a_high;
        logic b_high;
        logic tie;
    } verdict_t;

    localparam verdict_t VERDICT_TIE = '{a_high: 1'b0, b_high: 1'b0, tie: 1'b1};

    function automatic face_t face_next(face_t f);
        return (f == face_t'(FACE_MAX)) ? face_t'(FACE_MIN) : face_t'(f + 1'b1);
    endfunction

    function automatic seg_t face_glyph(face_t f);
        case (f)
            3'd1:    return 8'h06;
            3'd2:    return 8'h5B;
            3'd3:    return 8'h4F;
            3'd4:    return 8'h66;
            3'd5:    return 8'h6D;
            3'd6:    return 8'h7D;
            default: return 8'h00;
        endcase
    endfunction

    function automatic verdict_t judge(face_t a, face_t b);
        verdict_t v;
        v.a_high = (a > b);
        v.b_high = (a < b);
        v.tie    = (a == b);
        return v;
    endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int PERIOD = 6002
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/die_counter.sv
module die_counter
    import dice_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  roll_n,
    output face_t face
);
    always_ff @(posedge clk) begin
        if (rst)                 face <= face_t'(FACE_MIN);
        else if (step && !roll_n) face <= face_next(face);
    end

    assert_face_range_R6: assert property (@(posedge clk) disable iff (rst)
        (face >= face_t'(FACE_MIN)) && (face <= face_t'(FACE_MAX)));

    assert_hold_released_R7: assert property (@(posedge clk) disable iff (rst)
        roll_n |=> $stable(face));

    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(face));

endmodule

// File: rtl/result_judge.sv
module result_judge
    import dice_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  face_t    face_a,
    input  face_t    face_b,
    output verdict_t verdict
);
    always_ff @(posedge clk) begin
        if (rst) verdict <= VERDICT_TIE;
        else     verdict <= judge(face_a, face_b);
    end

    assert_one_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $countones({verdict.a_high, verdict.b_high, verdict.tie}) == 1);

    assert_a_ahead_R2: assert property (@(posedge clk) disable iff (rst)
        (face_a > face_b) |=> verdict.a_high);

    assert_b_ahead_R3: assert property (@(posedge clk) disable iff (rst)
        (face_a < face_b) |=> verdict.b_high);

    assert_even_R4: assert property (@(posedge clk) disable iff (rst)
        (face_a == face_b) |=> verdict.tie);

endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import dice_pkg::*;
(
    input  face_t face,
    output seg_t  seg
);
    always_comb begin
        seg = face_glyph(face);
        seg[SEG_W-1] = 1'b0;
    end
endmodule

// File: rtl/dice_duel.sv
module dice_duel
    import dice_pkg::*;
#(
    parameter int PERIOD_A = 6002,
    parameter int PERIOD_B = 14826
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       roll_a_n,
    input  logic       roll_b_n,
    output logic       a_high,
    output logic       b_high,
    output logic       tie,
    output logic [7:0] seg_a,
    output logic [7:0] seg_b
);
    localparam int NP = 2;
    localparam int PERIODS [NP] = '{PERIOD_A, PERIOD_B};

    logic [NP-1:0] ticks;
    logic [NP-1:0] rolls_n;
    face_t         faces [NP];
    seg_t          segs  [NP];
    verdict_t      verdict;

    assign rolls_n = {roll_b_n, roll_a_n};

    for (genvar p = 0; p < NP; p++) begin : g_player
        tick_gen #(.PERIOD(PERIODS[p])) u_tick (
            .clk  (clk),
            .rst  (rst),
            .tick (ticks[p])
        );
        die_counter u_die (
            .clk    (clk),
            .rst    (rst),
            .step   (ticks[p]),
            .roll_n (rolls_n[p]),
            .face   (faces[p])
        );
        seg_decode u_seg (
            .face (faces[p]),
            .seg  (segs[p])
        );
    end

    result_judge u_judge (
        .clk     (clk),
        .rst     (rst),
        .face_a  (faces[0]),
        .face_b  (faces[1]),
        .verdict (verdict)
    );

    assign a_high = verdict.a_high;
    assign b_high = verdict.b_high;
    assign tie    = verdict.tie;
    assign seg_a  = segs[0];
    assign seg_b  = segs[1];

    assert_dp_dark_R9: assert property (@(posedge clk) disable iff (rst)
        !seg_a[7] && !seg_b[7]);

endmodule

// File: tb/sim_dice_duel.sv
`timescale 1ns/1ps
module sim_dice_duel;
    localparam int PA = 3;
    localparam int PB = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic roll_a_n = 1'b1;
    logic roll_b_n = 1'b1;
    logic a_high, b_high, tie;
    logic [7:0] seg_a, seg_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int ma = 1, mb = 1, ca = 0, cb = 0;
    int ea = 0, eb = 0, et = 1;

    always #10 clk = ~clk;

    dice_duel #(.PERIOD_A(PA), .PERIOD_B(PB)) u0 (
        .clk(clk), .rst(rst), .roll_a_n(roll_a_n), .roll_b_n(roll_b_n),
        .a_high(a_high), .b_high(b_high), .tie(tie),
        .seg_a(seg_a), .seg_b(seg_b)
    );

    function automatic int glyph(int f);
        case (f)
            1: return 'h06;
            2: return 'h5B;
            3: return 'h4F;
            4: return 'h66;
            5: return 'h6D;
            6: return 'h7D;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string die_tag(bit r, bit tk, bit rl, int old);
        if (r) return "R1";
        if (tk && !rl && old == 6) return "R6";
        if (tk && !rl) return "R8";
        if (rl) return "R7";
        return "R9";
    endfunction

    task automatic step(bit ra, bit rb, bit r);
        bit ta, tb;
        int oa, ob;
        string tga, tgb, tgf;
        rst = r; roll_a_n = ra; roll_b_n = rb;
        @(posedge clk);
        oa = ma; ob = mb;
        if (r) begin
            ma = 1; mb = 1; ca = 0; cb = 0;
            ea = 0; eb = 0; et = 1;
            ta = 0; tb = 0;
            tgf = "R1";
        end else begin
            ea = (oa > ob); eb = (oa < ob); et = (oa == ob);
            tgf = (oa > ob) ? "R2" : ((oa < ob) ? "R3" : "R4");
            ta = (ca == PA - 1);
            tb = (cb == PB - 1);
            ca = ta ? 0 : ca + 1;
            cb = tb ? 0 : cb + 1;
            if (ta && !ra) ma = (ma == 6) ? 1 : ma + 1;
            if (tb && !rb) mb = (mb == 6) ? 1 : mb + 1;
        end
        tga = die_tag(r, ta, ra, oa);
        tgb = die_tag(r, tb, rb, ob);
        @(negedge clk);
        chk(tga, int'(seg_a), glyph(ma));
        chk(tgb, int'(seg_b), glyph(mb));
        chk(tgf, int'({a_high, b_high, tie}), (ea << 2) | (eb << 1) | et);
        if (!r) chk("R5", int'(a_high) + int'(b_high) + int'(tie), 1);
    endtask

    initial begin
        @(negedge clk);
        step(1, 1, 1);
        step(0, 0, 1);
        for (int i = 0; i < 200; i++) step(0, 0, 0);
        for (int i = 0; i < 100; i++) step(0, 1, 0);
        for (int i = 0; i < 100; i++) step(1, 0, 0);
        for (int i = 0; i < 60; i++)  step(1, 1, 0);
        for (int i = 0; i < 1500; i++) step((i % 7) < 3, (i % 11) < 5, 0);
        for (int i = 0; i < 13; i++)  step(0, 0, 0);
        step(0, 0, 1);
        for (int i = 0; i < 300; i++) step((i % 13) < 4, (i % 3) == 0, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule